// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Controller

This block routes a set of interrupt input lines to interrupt messages. Software sees only two 32-bit words on a simple bus: a select word and a data window. To reach an internal register, software first writes that register's index into the select word and then reads or writes the window. Behind the window sit an identification register and a redirection table. The table holds one two-word entry per input line. Each entry sets the line's vector, delivery mode, destination mode, destination, polarity, trigger mode and mask.

When a line is unmasked, its active edge or active level becomes a message: vector, delivery mode, destination mode and destination. The message is offered on a valid/ready output. If several lines are waiting, the lowest-numbered line is served first. Reads of the window return data combinationally in the same cycle. A write takes effect at the next clock edge.

Top module: `irq_redirect_router`

## Requirements
- R1: The select word sits at bus offset 0x00 and reads back all 32 bits last written to it. The window sits at bus offset 0x10 and reaches the internal register whose index is select bits [7:0]. Any other bus offset reads zero and ignores writes.
- R2: Internal index 0 is the identification register. Only bits 27:24 are writable and the other bits read zero. After reset these bits hold the ID_RESET parameter.
- R3: Line p has its low entry word at index 0x10+2p and its high word at 0x11+2p. The low word implements vector[7:0], delivery[10:8], destination mode[11] (1 = logical), polarity[13] (1 = active low), trigger[15] (1 = level) and mask[16] (1 = masked); all other low bits read zero. The high word implements destination[31:24] only. After reset the low word reads 0x00010000 and the high word reads 0.
- R4: An index that is neither 0 nor inside the table reads zero, and writes to it change no register.
- R5: A masked line produces no message. An active edge that arrives while the line is masked is not remembered after the line is unmasked.
- R6: An edge-triggered line latches its active edge as pending: rising when polarity is 0, falling when it is 1. It emits exactly one message per edge, and the pending state clears on the handshake. The opposite edge produces nothing.
- R7: A level-triggered line requests a message while its line is at the active level. After one message has been accepted, it requests nothing more until the line has returned to the inactive level.
- R8: A message carries the vector, delivery mode, destination mode and destination of the line that won, taken from its entry at the moment the message is captured.
- R9: When several lines are waiting, messages leave in ascending line number.
- R10: msg_valid is 0 after reset. Once raised, it stays high with all message fields stable until msg_ready is seen high on a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the bus access |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_in | input | NUM_PINS | Interrupt input lines, synchronous to clk |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | The message is accepted on this edge |
| msg_vector | output | 8 | Message vector |
| msg_dlv | output | 3 | Message delivery mode (0 fixed, 1 lowest priority, 2 SMI, 4 NMI, 5 INIT, 7 external) |
| msg_dmode | output | 1 | Message destination mode, 1 = logical |
| msg_dest | output | 8 | Message destination |

## Verification
The bench targets four kinds of error. First, the index decoding at the table edges and just past them: a decoder that is off by one would alias index 0x30 onto line 15, or write a high word into a low word. Second, bits the design does not implement leaking into read data. Third, polarity and masking: a design that latches edges while masked would send a stale message at unmask time, and one that ignores polarity would fire on the wrong edge. Fourth, the level-line lockout and ascending drain order, together with random sets of simultaneous edges drained against a bench-computed order; an arbiter that favoured the wrong end, or a level line that sent repeated messages, would then deliver the wrong vector.

// File: rtl/irr_pkg.sv
package irr_pkg;
   localparam int WORD_W    = 32;
   localparam int VEC_W     = 8;
   localparam int DLV_W     = 3;
   localparam int DEST_W    = 8;
   localparam int ID_W      = 4;
   // low entry word layout
   localparam int VEC_LSB   = 0;
   localparam int DLV_LSB   = 8;
   localparam int DMODE_BIT = 11;
   localparam int POL_BIT   = 13;
   localparam int TRIG_BIT  = 15;
   localparam int MASK_BIT  = 16;
   // high entry word and identification layout
   localparam int DEST_LSB  = 24;
   localparam int ID_LSB    = 24;

   typedef enum logic [DLV_W-1:0] {
      DLV_FIXED  = 3'd0,
      DLV_LOWPRI = 3'd1,
      DLV_SMI    = 3'd2,
      DLV_NMI    = 3'd4,
      DLV_INIT   = 3'd5,
      DLV_EXTINT = 3'd7
   } dlv_e;

   typedef struct packed {
      logic [DEST_W-1:0] dest;
      logic              dmode;
      logic [DLV_W-1:0]  dlv;
      logic [VEC_W-1:0]  vector;
   } irr_msg_t;
endpackage

// File: rtl/irr_regfile.sv
module irr_regfile
   import irr_pkg::*;
#(
   parameter int NUM_PINS   = 16,
   parameter int IDX_W      = 8,
   parameter int TABLE_BASE = 16,
   parameter int ADDR_W     = 5,
   parameter int SEL_OFF    = 0,
   parameter int WIN_OFF    = 16,
   parameter int ID_RESET   = 0
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [ADDR_W-1:0]               bus_addr,
   input  logic                            bus_wr,
   input  logic [WORD_W-1:0]               bus_wdata,
   output logic [WORD_W-1:0]               bus_rdata,
   output logic [NUM_PINS-1:0][VEC_W-1:0]  cfg_vec,
   output logic [NUM_PINS-1:0][DLV_W-1:0]  cfg_dlv,
   output logic [NUM_PINS-1:0]             cfg_dmode,
   output logic [NUM_PINS-1:0]             cfg_pol,
   output logic [NUM_PINS-1:0]             cfg_trig,
   output logic [NUM_PINS-1:0]             cfg_mask,
   output logic [NUM_PINS-1:0][DEST_W-1:0] cfg_dest
);
   localparam int PIN_W     = $clog2(NUM_PINS);
   localparam int TABLE_END = TABLE_BASE + 2 * NUM_PINS;

   logic [WORD_W-1:0] sel_q;
   logic [ID_W-1:0]   id_q;
   logic [IDX_W-1:0]  idx;
   logic [IDX_W-1:0]  off;
   logic [PIN_W-1:0]  pin_sel;
   logic              odd, in_tab, is_id, sel_hit, win_hit, win_wr;
   logic [WORD_W-1:0] win_val;

   assign idx     = sel_q[IDX_W-1:0];
   assign off     = idx - IDX_W'(TABLE_BASE);
   assign pin_sel = PIN_W'(off >> 1);
   assign odd     = off[0];
   assign in_tab  = (int'(idx) >= TABLE_BASE) && (int'(idx) < TABLE_END);
   assign is_id   = (idx == '0);
   assign sel_hit = (bus_addr == ADDR_W'(SEL_OFF));
   assign win_hit = (bus_addr == ADDR_W'(WIN_OFF));
   assign win_wr  = bus_wr && win_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         id_q  <= ID_W'(ID_RESET);
      end else begin
         if (bus_wr && sel_hit) sel_q <= bus_wdata;
         if (win_wr && is_id)   id_q  <= bus_wdata[ID_LSB +: ID_W];
      end
   end

   // redirection table storage: only implemented fields are kept
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_vec   <= '0;
         cfg_dlv   <= '0;
         cfg_dmode <= '0;
         cfg_pol   <= '0;
         cfg_trig  <= '0;
         cfg_mask  <= '1;
         cfg_dest  <= '0;
      end else if (win_wr && in_tab) begin
         for (int p = 0; p < NUM_PINS; p++) begin
            if (pin_sel == PIN_W'(p)) begin
               if (odd) begin
                  cfg_dest[p] <= bus_wdata[DEST_LSB +: DEST_W];
               end else begin
                  cfg_vec[p]   <= bus_wdata[VEC_LSB +: VEC_W];
                  cfg_dlv[p]   <= bus_wdata[DLV_LSB +: DLV_W];
                  cfg_dmode[p] <= bus_wdata[DMODE_BIT];
                  cfg_pol[p]   <= bus_wdata[POL_BIT];
                  cfg_trig[p]  <= bus_wdata[TRIG_BIT];
                  cfg_mask[p]  <= bus_wdata[MASK_BIT];
               end
            end
         end
      end
   end

   always_comb begin
      win_val = '0;
      if (is_id) begin
         win_val[ID_LSB +: ID_W] = id_q;
      end else if (in_tab) begin
         if (odd) begin
            win_val[DEST_LSB +: DEST_W] = cfg_dest[pin_sel];
         end else begin
            win_val[VEC_LSB +: VEC_W] = cfg_vec[pin_sel];
            win_val[DLV_LSB +: DLV_W] = cfg_dlv[pin_sel];
            win_val[DMODE_BIT]        = cfg_dmode[pin_sel];
            win_val[POL_BIT]          = cfg_pol[pin_sel];
            win_val[TRIG_BIT]         = cfg_trig[pin_sel];
            win_val[MASK_BIT]         = cfg_mask[pin_sel];
         end
      end
   end

   assign bus_rdata = sel_hit ? sel_q : (win_hit ? win_val : '0);
endmodule

// File: rtl/irr_pin_front.sv
module irr_pin_front #(
   parameter int NUM_PINS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] irq_in,
   input  logic [NUM_PINS-1:0] cfg_pol,
   input  logic [NUM_PINS-1:0] cfg_trig,
   input  logic [NUM_PINS-1:0] cfg_mask,
   input  logic [NUM_PINS-1:0] grant,
   output logic [NUM_PINS-1:0] req
);
   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic act, prev_q, pend_q, done_q, edge_hit;

      assign act      = irq_in[p] ^ cfg_pol[p];
      assign edge_hit = act && !prev_q && !cfg_trig[p] && !cfg_mask[p];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
            done_q <= 1'b0;
         end else begin
            prev_q <= act;
            pend_q <= (pend_q && !grant[p]) || edge_hit;
            done_q <= (done_q || (grant[p] && cfg_trig[p])) && act;
         end
      end

      assign req[p] = !cfg_mask[p] && (cfg_trig[p] ? (act && !done_q) : pend_q);
   end
endmodule

// File: rtl/irr_arbiter.sv
module irr_arbiter
   import irr_pkg::*;
#(
   parameter int NUM_PINS = 16
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_PINS-1:0]             req,
   input  logic [NUM_PINS-1:0][VEC_W-1:0]  cfg_vec,
   input  logic [NUM_PINS-1:0][DLV_W-1:0]  cfg_dlv,
   input  logic [NUM_PINS-1:0]             cfg_dmode,
   input  logic [NUM_PINS-1:0][DEST_W-1:0] cfg_dest,
   input  logic                            msg_ready,
   output logic [NUM_PINS-1:0]             grant,
   output logic                            msg_valid,
   output irr_msg_t                        msg
);
   logic [NUM_PINS-1:0] lowest;
   irr_msg_t            pick;

   assign lowest = req & (~req + 1'b1);
   assign grant  = msg_valid ? '0 : lowest;

   always_comb begin
      pick = '0;
      for (int p = 0; p < NUM_PINS; p++) begin
         if (grant[p]) begin
            pick.vector = pick.vector | cfg_vec[p];
            pick.dlv    = pick.dlv    | cfg_dlv[p];
            pick.dmode  = pick.dmode  | cfg_dmode[p];
            pick.dest   = pick.dest   | cfg_dest[p];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msg_valid <= 1'b0;
         msg       <= '0;
      end else if (|grant) begin
         msg_valid <= 1'b1;
         msg       <= pick;
      end else if (msg_ready) begin
         msg_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_redirect_router.sv
module irq_redirect_router
   import irr_pkg::*;
#(
   parameter int NUM_PINS   = 16,
   parameter int IDX_W      = 8,
   parameter int TABLE_BASE = 16,
   parameter int ADDR_W     = 5,
   parameter int SEL_OFF    = 0,
   parameter int WIN_OFF    = 16,
   parameter int ID_RESET   = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic [NUM_PINS-1:0] irq_in,
   output logic                msg_valid,
   input  logic                msg_ready,
   output logic [7:0]          msg_vector,
   output logic [2:0]          msg_dlv,
   output logic                msg_dmode,
   output logic [7:0]          msg_dest
);
   if (NUM_PINS < 2) begin : g_chk_pins
      $error("NUM_PINS must be at least 2");
   end
   if (TABLE_BASE < 2 || (TABLE_BASE % 2) != 0) begin : g_chk_base
      $error("TABLE_BASE must be even and above the identification index");
   end
   if (IDX_W > 32 || TABLE_BASE + 2 * NUM_PINS > (1 << IDX_W)) begin : g_chk_idx
      $error("IDX_W too narrow for the redirection table");
   end
   if (SEL_OFF == WIN_OFF || SEL_OFF >= (1 << ADDR_W) || WIN_OFF >= (1 << ADDR_W)) begin : g_chk_off
      $error("bus offsets must differ and fit in ADDR_W");
   end
   if (ID_RESET < 0 || ID_RESET > 15) begin : g_chk_id
      $error("ID_RESET must fit in four bits");
   end

   logic [NUM_PINS-1:0][VEC_W-1:0]  cfg_vec;
   logic [NUM_PINS-1:0][DLV_W-1:0]  cfg_dlv;
   logic [NUM_PINS-1:0][DEST_W-1:0] cfg_dest;
   logic [NUM_PINS-1:0]             cfg_dmode, cfg_pol, cfg_trig, cfg_mask;
   logic [NUM_PINS-1:0]             req_w, grant_w;
   irr_msg_t                        msg_q;

   irr_regfile #(
      .NUM_PINS(NUM_PINS), .IDX_W(IDX_W), .TABLE_BASE(TABLE_BASE),
      .ADDR_W(ADDR_W), .SEL_OFF(SEL_OFF), .WIN_OFF(WIN_OFF), .ID_RESET(ID_RESET)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cfg_vec(cfg_vec), .cfg_dlv(cfg_dlv), .cfg_dmode(cfg_dmode), .cfg_pol(cfg_pol),
      .cfg_trig(cfg_trig), .cfg_mask(cfg_mask), .cfg_dest(cfg_dest)
   );

   irr_pin_front #(.NUM_PINS(NUM_PINS)) u_front (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .cfg_pol(cfg_pol), .cfg_trig(cfg_trig), .cfg_mask(cfg_mask),
      .grant(grant_w), .req(req_w)
   );

   irr_arbiter #(.NUM_PINS(NUM_PINS)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(req_w),
      .cfg_vec(cfg_vec), .cfg_dlv(cfg_dlv), .cfg_dmode(cfg_dmode), .cfg_dest(cfg_dest),
      .msg_ready(msg_ready), .grant(grant_w), .msg_valid(msg_valid), .msg(msg_q)
   );

   assign msg_vector = msg_q.vector;
   assign msg_dlv    = msg_q.dlv;
   assign msg_dmode  = msg_q.dmode;
   assign msg_dest   = msg_q.dest;
endmodule

// File: rtl/irr_checker.sv
module irr_checker #(
   parameter int NUM_PINS = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                msg_valid,
   input logic                msg_ready,
   input logic [7:0]          msg_vector,
   input logic [2:0]          msg_dlv,
   input logic                msg_dmode,
   input logic [7:0]          msg_dest,
   input logic [NUM_PINS-1:0] grant,
   input logic [NUM_PINS-1:0] pin_mask
);
   AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && !msg_ready |=> msg_valid); // R10

   AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && !msg_ready |=> $stable(msg_vector) && $stable(msg_dlv)
                                  && $stable(msg_dmode) && $stable(msg_dest)); // R10

   AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R9

   AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & pin_mask) == '0); // R5

   AST_VALID_FROM_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && !$past(msg_valid) |-> $past(|grant)); // R8
endmodule

bind irq_redirect_router irr_checker #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
   .msg_vector(msg_vector), .msg_dlv(msg_dlv), .msg_dmode(msg_dmode),
   .msg_dest(msg_dest), .grant(grant_w), .pin_mask(cfg_mask)
);

// File: tb/sim_irq_redirect_router.sv
module sim_irq_redirect_router;
   import irr_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int NP         = 16;
   localparam int ID_VAL     = 9;
   localparam logic [4:0] A_SEL = 5'h00;
   localparam logic [4:0] A_WIN = 5'h10;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [4:0]    bus_addr;
   logic          bus_wr;
   logic [31:0]   bus_wdata;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] irq_in;
   logic          msg_valid, msg_ready;
   logic [7:0]    msg_vector, msg_dest;
   logic [2:0]    msg_dlv;
   logic          msg_dmode;

   int checks = 0;
   int fails  = 0;

   irq_redirect_router #(.NUM_PINS(NP), .ID_RESET(ID_VAL)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
      .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
      .msg_dlv(msg_dlv), .msg_dmode(msg_dmode), .msg_dest(msg_dest)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   function automatic logic [31:0] lo_word(input logic [7:0] vec, input logic [2:0] dlv,
                                           input logic dm, input logic pol,
                                           input logic trig, input logic mask);
      return (32'(vec)) | (32'(dlv) << 8) | (32'(dm) << 11) | (32'(pol) << 13)
           | (32'(trig) << 15) | (32'(mask) << 16);
   endfunction

   function automatic logic [31:0] msg_word(input logic [7:0] vec, input logic [2:0] dlv,
                                            input logic dm, input logic [7:0] dest);
      return {12'h0, dest, dm, dlv, vec};
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic reg_write(input logic [7:0] idx, input logic [31:0] d);
      bus_write(A_SEL, {24'h0, idx});
      bus_write(A_WIN, d);
   endtask

   task automatic reg_read(input logic [7:0] idx, output logic [31:0] d);
      bus_write(A_SEL, {24'h0, idx});
      bus_read(A_WIN, d);
   endtask

   task automatic program_pin(input int p, input logic [7:0] vec, input logic [2:0] dlv,
                              input logic dm, input logic pol, input logic trig,
                              input logic mask, input logic [7:0] dest);
      reg_write(8'(16 + 2 * p + 1), {dest, 24'h0});
      reg_write(8'(16 + 2 * p), lo_word(vec, dlv, dm, pol, trig, mask));
   endtask

   task automatic take_msg(input string tag, input logic [31:0] exp);
      chk({tag, " valid"}, 32'(msg_valid), 32'd1);
      chk({tag, " fields"}, msg_word(msg_vector, msg_dlv, msg_dmode, msg_dest), exp);
      msg_ready = 1'b1;
      @(negedge clk);
      msg_ready = 1'b0;
      @(negedge clk);
   endtask

   logic [31:0] rd;
   logic [7:0]  rvec  [NP];
   logic [7:0]  rdest [NP];

   initial begin
      void'($urandom(32'd4242));
      rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
      irq_in = '0; msg_ready = 1'b0;
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // reset state
      chk("R10 reset valid", 32'(msg_valid), 32'd0);
      bus_read(A_SEL, rd);                chk("R1 reset select", rd, 32'h0);
      reg_read(8'h00, rd);                chk("R2 reset id", rd, 32'(ID_VAL) << 24);
      reg_read(8'h1A, rd);                chk("R3 reset low word pin5", rd, 32'h0001_0000);
      reg_read(8'h1B, rd);                chk("R3 reset high word pin5", rd, 32'h0);

      // select word keeps its upper bits, window follows low byte
      bus_write(A_SEL, 32'hABCD_0021);
      bus_read(A_SEL, rd);                chk("R1 select readback", rd, 32'hABCD_0021);
      bus_write(A_WIN, 32'hFFFF_FFFF);
      bus_read(A_WIN, rd);                chk("R3 high word implemented bits", rd, 32'hFF00_0000);
      reg_read(8'h20, rd);                chk("R3 low word beside high untouched", rd, 32'h0001_0000);
      reg_write(8'h10, 32'hFFFF_FFFF);
      reg_read(8'h10, rd);                chk("R3 low word implemented bits", rd, 32'h0001_AFFF);
      reg_write(8'h10, 32'h0001_0000);
      reg_write(8'h00, 32'hFFFF_FFFF);
      reg_read(8'h00, rd);                chk("R2 id implemented bits", rd, 32'h0F00_0000);

      // unimplemented indices and bus offsets
      reg_write(8'h05, 32'hFFFF_FFFF);
      reg_read(8'h05, rd);                chk("R4 index 0x05", rd, 32'h0);
      reg_write(8'h30, 32'hFFFF_FFFF);
      reg_read(8'h30, rd);                chk("R4 index past table", rd, 32'h0);
      reg_read(8'h2F, rd);                chk("R4 last high word untouched", rd, 32'h0);
      reg_read(8'h2E, rd);                chk("R4 last low word untouched", rd, 32'h0001_0000);
      reg_write(8'hFF, 32'h1234_5678);
      reg_read(8'hFF, rd);                chk("R4 index 0xFF", rd, 32'h0);
      bus_write(A_SEL, 32'h0000_0000);
      bus_write(5'h08, 32'hDEAD_BEEF);
      bus_read(5'h08, rd);                chk("R1 other offset reads zero", rd, 32'h0);
      bus_read(A_SEL, rd);                chk("R1 other offset write ignored", rd, 32'h0);
      reg_read(8'h00, rd);                chk("R1 id unchanged by stray write", rd, 32'h0F00_0000);

      // masked line: no message, edge not remembered
      program_pin(2, 8'h41, DLV_LOWPRI, 1'b1, 1'b0, 1'b0, 1'b1, 8'h5A);
      irq_in[2] = 1'b1;
      tick(4);                            chk("R5 masked edge", 32'(msg_valid), 32'd0);
      program_pin(2, 8'h41, DLV_LOWPRI, 1'b1, 1'b0, 1'b0, 1'b0, 8'h5A);
      tick(4);                            chk("R5 edge while masked dropped", 32'(msg_valid), 32'd0);
      reg_read(8'h14, rd);                chk("R3 programmed low word", rd, 32'h0000_0941);

      // edge message, one per edge
      irq_in[2] = 1'b0; tick(1);
      irq_in[2] = 1'b1; tick(3);
      take_msg("R6 R8 edge pin2", msg_word(8'h41, DLV_LOWPRI, 1'b1, 8'h5A));
      tick(3);                            chk("R6 single message per edge", 32'(msg_valid), 32'd0);
      irq_in[2] = 1'b0; tick(2);          chk("R6 inactive edge silent", 32'(msg_valid), 32'd0);

      // active-low line
      irq_in[4] = 1'b1; tick(1);
      program_pin(4, 8'h44, DLV_NMI, 1'b0, 1'b1, 1'b0, 1'b0, 8'h03);
      tick(2);                            chk("R6 pol-low idle", 32'(msg_valid), 32'd0);
      irq_in[4] = 1'b0; tick(3);
      take_msg("R6 falling edge pin4", msg_word(8'h44, DLV_NMI, 1'b0, 8'h03));
      irq_in[4] = 1'b1; tick(4);          chk("R6 rising edge on pol-low", 32'(msg_valid), 32'd0);
      program_pin(4, 8'h44, DLV_NMI, 1'b0, 1'b1, 1'b0, 1'b1, 8'h03);
      irq_in[4] = 1'b0; tick(3);          chk("R5 masked pol-low edge", 32'(msg_valid), 32'd0);

      // level line lockout
      program_pin(6, 8'h66, DLV_FIXED, 1'b0, 1'b0, 1'b1, 1'b0, 8'hC1);
      irq_in[6] = 1'b1; tick(2);
      take_msg("R7 level first", msg_word(8'h66, DLV_FIXED, 1'b0, 8'hC1));
      tick(4);                            chk("R7 level lockout", 32'(msg_valid), 32'd0);
      irq_in[6] = 1'b0; tick(2);          chk("R7 level inactive", 32'(msg_valid), 32'd0);
      irq_in[6] = 1'b1; tick(2);
      take_msg("R7 level rearmed", msg_word(8'h66, DLV_FIXED, 1'b0, 8'hC1));
      irq_in[6] = 1'b0; tick(2);

      // ascending drain order with hold check
      foreach (rvec[p]) begin
         if (p == 1 || p == 3 || p == 7 || p == 12)
            program_pin(p, 8'(8'h80 + p), DLV_EXTINT, 1'b1, 1'b0, 1'b0, 1'b0, 8'(p));
      end
      irq_in[1] = 1'b1; irq_in[3] = 1'b1; irq_in[7] = 1'b1; irq_in[12] = 1'b1;
      tick(3);
      chk("R10 hold vector", 32'(msg_vector), 32'h81);
      tick(4);
      chk("R10 hold after wait", 32'(msg_vector), 32'h81);
      take_msg("R9 order 1", msg_word(8'h81, DLV_EXTINT, 1'b1, 8'd1));
      take_msg("R9 order 3", msg_word(8'h83, DLV_EXTINT, 1'b1, 8'd3));
      take_msg("R9 order 7", msg_word(8'h87, DLV_EXTINT, 1'b1, 8'd7));
      take_msg("R9 order 12", msg_word(8'h8C, DLV_EXTINT, 1'b1, 8'd12));
      chk("R9 drained", 32'(msg_valid), 32'd0);
      irq_in = '0; tick(2);

      // random sets of simultaneous edges
      for (int it = 0; it < 20; it++) begin
         logic [NP-1:0] fire, msk;
         fire = NP'($urandom);
         msk  = NP'($urandom) & NP'($urandom);
         for (int p = 0; p < NP; p++) begin
            rvec[p]  = 8'($urandom);
            rdest[p] = 8'($urandom);
            program_pin(p, rvec[p], 3'd0, 1'b0, 1'b0, 1'b0, msk[p], rdest[p]);
         end
         irq_in = fire; tick(3);
         for (int p = 0; p < NP; p++) begin
            if (fire[p] && !msk[p])
               take_msg("R9 R8 random drain", msg_word(rvec[p], 3'd0, 1'b0, rdest[p]));
         end
         chk("R5 R9 random empty", 32'(msg_valid), 32'd0);
         irq_in = '0; tick(2);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule